// File: doc/BRIEF.md
# Collision-Safe Shared Status Register Bank

This block holds a small bank of status registers. Each register has some bits that both the processor and hardware events can change, and some bits that only the processor writes. A hardware event on a shared bit arrives as a single-cycle set strobe. If nothing guards it, a processor read-modify-write can erase such an event. The erased event may sit in the bit being rewritten, or in a neighbouring bit that the processor writes back with a stale value.

To prevent this, the processor raises a guard flag before its read-modify-write sequence and drops it afterwards. Every shared bit has two storage flops: a visible standard copy and a hidden shadow copy. While the guard is up, hardware strobes go only into the shadow and processor writes go only into the standard copy. When the guard drops, the shadow is ORed into the standard copy and cleared in the same cycle. So an event taken during the guarded window shows up as a set bit as soon as the window closes.

Top module: `sreg_bank`

## Requirements
- R1: A read issued with `reg_rd` in one cycle presents the standard copy of register `reg_addr` on `reg_rdata` after the next rising clock edge. The value is held until the next read. Shadow contents never appear on `reg_rdata`.
- R2: `guard_q` changes only in a cycle with `guard_wr` asserted, where it takes `guard_wdata`. Hardware strobes and register writes never alter it.
- R3: With the guard at 0, a strobe on `hw_set[r*DATA_W+b]` sets bit b of register r, if that bit is shared, from the next clock edge on. With the default parameters the shared bits are bits 0 to 3 of each register.
- R4: With the guard at 1, a hardware strobe leaves the visible register value unchanged and is recorded in the shadow copy of that bit.
- R5: With the guard at 1, processor writes update the standard copy normally, so writing 0 clears a shared bit.
- R6: In the cycle the guard goes from 1 to 0, the shadow copies are ORed into the standard copies. An event taken during the window reads back as 1 after release. This holds even if the processor cleared that bit during the window, and even if the processor wrote a stale 0 to it while updating a different bit of the same register.
- R7: A strobe that arrives in the very cycle the guard is released reaches the standard copy at that edge.
- R8: With the guard at 0, a strobe and a processor write of 0 to the same shared bit in the same cycle leave the bit at 1.
- R9: Non-shared bits (bits 4 to 7 by default) ignore hardware strobes. They take processor writes whatever the guard state.
- R10: Synchronous active-high reset clears all standard copies, all shadow copies, the guard flag and `reg_rdata`.
- R11: A release empties the shadow. A later guarded window with no events, in which a bit is cleared, leaves that bit at 0 after its own release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register index for read or write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data (standard copy) |
| guard_wr | input | 1 | Write strobe for the guard flag |
| guard_wdata | input | 1 | New guard flag value |
| guard_q | output | 1 | Current guard flag |
| hw_set | input | NUM_REGS*DATA_W | Hardware set strobes, bit r*DATA_W+b targets register r bit b |

## Verification
A shadow copy that is not cleared on release shows at the ports only in a later window. Clearing a bit and releasing again brings back a stale 1 one read after that release. A shadow bit that is set wrongly, or never set, shows as a wrong value on the first read after release. That read is two edges after the release cycle. Misrouting a strobe into the standard copy while guarded shows on the next read inside the window, before any release. A wrong priority between a write and a strobe shows on the first read after that collision cycle.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

  // Phase of the guard window as seen by each bit in the current cycle.
  typedef enum logic [1:0] {
    PH_OPEN    = 2'd0,  // guard low: strobes land in standard copy
    PH_GUARDED = 2'd1,  // guard high and staying high: strobes go to shadow
    PH_RELEASE = 2'd2   // guard high now, being cleared this cycle: merge
  } guard_phase_e;

endpackage

// File: rtl/sreg_guard_ctrl.sv
module sreg_guard_ctrl
  import sreg_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         guard_wr,
  input  logic         guard_wdata,
  output logic         guard_q,
  output guard_phase_e phase
);

  always_ff @(posedge clk) begin
    if (rst)
      guard_q <= 1'b0;
    else if (guard_wr)
      guard_q <= guard_wdata;
  end

  always_comb begin
    if (!guard_q)
      phase = PH_OPEN;
    else if (guard_wr && !guard_wdata)
      phase = PH_RELEASE;
    else
      phase = PH_GUARDED;
  end

endmodule

// File: rtl/sreg_row.sv
module sreg_row
  import sreg_pkg::*;
#(
  parameter int          DATA_W      = 8,
  parameter logic [DATA_W-1:0] SHARED_MASK = 8'h0F
) (
  input  logic              clk,
  input  logic              rst,
  input  guard_phase_e      phase,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] hw_set,
  output logic [DATA_W-1:0] std_q,
  output logic [DATA_W-1:0] shd_q
);

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    // processor view of the bit after this cycle's write
    logic wbit;
    assign wbit = wr_hit ? wdata[b] : std_q[b];

    if (SHARED_MASK[b]) begin : g_shared
      logic std_n;
      logic shd_n;

      always_comb begin
        unique case (phase)
          PH_GUARDED: begin
            std_n = wbit;
            shd_n = shd_q[b] | hw_set[b];
          end
          PH_RELEASE: begin
            std_n = wbit | shd_q[b] | hw_set[b];
            shd_n = 1'b0;
          end
          default: begin
            std_n = wbit | hw_set[b];
            shd_n = 1'b0;
          end
        endcase
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          std_q[b] <= 1'b0;
          shd_q[b] <= 1'b0;
        end else begin
          std_q[b] <= std_n;
          shd_q[b] <= shd_n;
        end
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst)
          std_q[b] <= 1'b0;
        else
          std_q[b] <= wbit;
      end
      assign shd_q[b] = 1'b0;
    end
  end

endmodule

// File: rtl/sreg_read_port.sv
module sreg_read_port #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] regs [NUM_REGS],
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_addr == ADDR_W'(i))
        sel = regs[i];
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (rd_en)
      rdata <= sel;
  end

endmodule

// File: rtl/sreg_bank.sv
module sreg_bank
  import sreg_pkg::*;
#(
  parameter int          NUM_REGS    = 4,
  parameter int          DATA_W      = 8,
  parameter logic [DATA_W-1:0] SHARED_MASK = 8'h0F,
  parameter int          ADDR_W      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       reg_wr,
  input  logic                       reg_rd,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [DATA_W-1:0]          reg_wdata,
  output logic [DATA_W-1:0]          reg_rdata,
  input  logic                       guard_wr,
  input  logic                       guard_wdata,
  output logic                       guard_q,
  input  logic [NUM_REGS*DATA_W-1:0] hw_set
);

  localparam int FLAT_W = NUM_REGS * DATA_W;

  guard_phase_e      phase;
  logic [DATA_W-1:0] row_std [NUM_REGS];
  logic [DATA_W-1:0] row_shd [NUM_REGS];
  logic [FLAT_W-1:0] std_flat;
  logic [FLAT_W-1:0] shd_flat;

  sreg_guard_ctrl i_guard (
    .clk         (clk),
    .rst         (rst),
    .guard_wr    (guard_wr),
    .guard_wdata (guard_wdata),
    .guard_q     (guard_q),
    .phase       (phase)
  );

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_row
    localparam logic [ADDR_W-1:0] IDX = ADDR_W'(r);
    logic hit;
    assign hit = reg_wr && (reg_addr == IDX);

    sreg_row #(
      .DATA_W      (DATA_W),
      .SHARED_MASK (SHARED_MASK)
    ) i_row (
      .clk    (clk),
      .rst    (rst),
      .phase  (phase),
      .wr_hit (hit),
      .wdata  (reg_wdata),
      .hw_set (hw_set[r*DATA_W +: DATA_W]),
      .std_q  (row_std[r]),
      .shd_q  (row_shd[r])
    );

    assign std_flat[r*DATA_W +: DATA_W] = row_std[r];
    assign shd_flat[r*DATA_W +: DATA_W] = row_shd[r];
  end

  sreg_read_port #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W)
  ) i_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (reg_rd),
    .rd_addr (reg_addr),
    .regs    (row_std),
    .rdata   (reg_rdata)
  );

endmodule

// File: rtl/sreg_bank_chk.sv
module sreg_bank_chk #(
  parameter int          NUM_REGS    = 4,
  parameter int          DATA_W      = 8,
  parameter logic [DATA_W-1:0] SHARED_MASK = 8'h0F
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       reg_wr,
  input logic                       guard_wr,
  input logic                       guard_wdata,
  input logic                       guard_q,
  input logic [NUM_REGS*DATA_W-1:0] hw_set,
  input logic [NUM_REGS*DATA_W-1:0] std_flat,
  input logic [NUM_REGS*DATA_W-1:0] shd_flat
);

  localparam logic [NUM_REGS*DATA_W-1:0] MASK_ALL = {NUM_REGS{SHARED_MASK}};

  logic [NUM_REGS*DATA_W-1:0] hw_sh;
  logic                       releasing;
  assign hw_sh     = hw_set & MASK_ALL;
  assign releasing = guard_q && guard_wr && !guard_wdata;

  AST_GUARD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !guard_wr |=> $stable(guard_q)); // R2

  AST_SHADOW_IDLE: assert property (@(posedge clk) disable iff (rst)
    !guard_q |-> (shd_flat == '0)); // R3

  AST_OPEN_STROBE: assert property (@(posedge clk) disable iff (rst)
    (!guard_q && (hw_sh != '0)) |=> ((std_flat & $past(hw_sh)) == $past(hw_sh))); // R3

  AST_SHADOW_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (guard_q && !releasing) |=> ((shd_flat & $past(hw_sh)) == $past(hw_sh))); // R4

  AST_STD_HIDDEN: assert property (@(posedge clk) disable iff (rst)
    (guard_q && !releasing && !reg_wr) |=> $stable(std_flat)); // R4

  AST_MERGE: assert property (@(posedge clk) disable iff (rst)
    (releasing && !reg_wr) |=> (((std_flat & $past(shd_flat)) == $past(shd_flat)) && (shd_flat == '0))); // R6

  AST_NONSHARED_HOLD: assert property (@(posedge clk) disable iff (rst)
    !reg_wr |=> $stable(std_flat & ~MASK_ALL)); // R9

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> ((std_flat == '0) && (shd_flat == '0) && !guard_q)); // R10

endmodule

bind sreg_bank sreg_bank_chk #(
  .NUM_REGS    (NUM_REGS),
  .DATA_W      (DATA_W),
  .SHARED_MASK (SHARED_MASK)
) i_chk (
  .clk         (clk),
  .rst         (rst),
  .reg_wr      (reg_wr),
  .guard_wr    (guard_wr),
  .guard_wdata (guard_wdata),
  .guard_q     (guard_q),
  .hw_set      (hw_set),
  .std_flat    (std_flat),
  .shd_flat    (shd_flat)
);

// File: tb/test_sreg_bank.sv
`timescale 1ns/1ps
module test_sreg_bank;

  localparam int NR = 4;
  localparam int DW = 8;
  localparam int AW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr = 1'b0;
  logic          reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          guard_wr = 1'b0;
  logic          guard_wdata = 1'b0;
  logic          guard_q;
  logic [NR*DW-1:0] hw_set = '0;

  int n_checks = 0;
  int n_fail   = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  sreg_bank #(.NUM_REGS(NR), .DATA_W(DW), .SHARED_MASK(8'h0F)) i_sreg_bank (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .guard_wr(guard_wr),
    .guard_wdata(guard_wdata), .guard_q(guard_q), .hw_set(hw_set)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock cycle of stimulus, driven at a falling edge, released at the next.
  task automatic cyc(input logic wr, input int addr, input logic [DW-1:0] wd,
                     input logic gwr, input logic gval, input logic [NR*DW-1:0] hw);
    reg_wr = wr; reg_addr = AW'(addr); reg_wdata = wd;
    guard_wr = gwr; guard_wdata = gval; hw_set = hw;
    @(negedge clk);
    reg_wr = 1'b0; guard_wr = 1'b0; hw_set = '0;
  endtask

  task automatic wr_reg(input int addr, input logic [DW-1:0] d);
    cyc(1'b1, addr, d, 1'b0, 1'b0, '0);
  endtask

  task automatic set_guard(input logic v);
    cyc(1'b0, 0, '0, 1'b1, v, '0);
  endtask

  task automatic strobe(input int r, input int b);
    logic [NR*DW-1:0] v;
    v = '0;
    v[r*DW+b] = 1'b1;
    cyc(1'b0, 0, '0, 1'b0, 1'b0, v);
  endtask

  task automatic rd_reg(input int addr, output logic [DW-1:0] d);
    reg_rd = 1'b1; reg_addr = AW'(addr);
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    chk("R10 guard after reset", {7'd0, guard_q}, 8'h00);
    chk("R10 rdata after reset", reg_rdata, 8'h00);
    for (int r = 0; r < NR; r++) begin
      rd_reg(r, d);
      chk("R10 register after reset", d, 8'h00);
    end
  endtask

  task automatic t_open_strobe();
    logic [DW-1:0] d;
    strobe(1, 2);
    rd_reg(1, d);
    chk("R3 open strobe sets bit", d, 8'h04);
    chk("R1 rdata held after read", reg_rdata, 8'h04);
    wr_reg(1, 8'h00);
    rd_reg(1, d);
    chk("R1 read after clear", d, 8'h00);
  endtask

  task automatic t_priority();
    logic [DW-1:0] d;
    logic [NR*DW-1:0] v;
    v = '0; v[1*DW+0] = 1'b1;
    cyc(1'b1, 1, 8'h00, 1'b0, 1'b0, v);
    rd_reg(1, d);
    chk("R8 strobe beats write of 0", d, 8'h01);
    wr_reg(1, 8'h00);
  endtask

  task automatic t_guard_hidden();
    logic [DW-1:0] d;
    set_guard(1'b1);
    chk("R2 guard set", {7'd0, guard_q}, 8'h01);
    strobe(2, 1);
    rd_reg(2, d);
    chk("R4 guarded strobe not visible", d, 8'h00);
    wr_reg(2, 8'h08);
    rd_reg(2, d);
    chk("R5 guarded write lands", d, 8'h08);
    chk("R2 guard unchanged by traffic", {7'd0, guard_q}, 8'h01);
    set_guard(1'b0);
    chk("R2 guard cleared", {7'd0, guard_q}, 8'h00);
    rd_reg(2, d);
    chk("R6 shadow merged on release", d, 8'h0A);
  endtask

  task automatic t_neighbour();
    logic [DW-1:0] d;
    wr_reg(3, 8'h01);
    set_guard(1'b1);
    rd_reg(3, d);
    chk("R5 read inside window", d, 8'h01);
    strobe(3, 2);
    wr_reg(3, d | 8'h10);
    set_guard(1'b0);
    rd_reg(3, d);
    chk("R6 neighbour event survives stale write", d, 8'h15);
  endtask

  task automatic t_same_bit();
    logic [DW-1:0] d;
    wr_reg(0, 8'h00);
    strobe(0, 0);
    set_guard(1'b1);
    strobe(0, 0);
    wr_reg(0, 8'h00);
    rd_reg(0, d);
    chk("R5 guarded clear visible", d, 8'h00);
    set_guard(1'b0);
    rd_reg(0, d);
    chk("R6 same-bit event survives clear", d, 8'h01);
  endtask

  task automatic t_release_strobe();
    logic [DW-1:0] d;
    logic [NR*DW-1:0] v;
    set_guard(1'b1);
    v = '0; v[0*DW+3] = 1'b1;
    cyc(1'b0, 0, '0, 1'b1, 1'b0, v);
    rd_reg(0, d);
    chk("R7 strobe in release cycle", d, 8'h09);
  endtask

  task automatic t_shadow_empty();
    logic [DW-1:0] d;
    set_guard(1'b1);
    wr_reg(0, 8'h00);
    set_guard(1'b0);
    rd_reg(0, d);
    chk("R11 no stale shadow after release", d, 8'h00);
  endtask

  task automatic t_nonshared();
    logic [DW-1:0] d;
    wr_reg(1, 8'h00);
    strobe(1, 7);
    rd_reg(1, d);
    chk("R9 strobe on plain bit ignored", d, 8'h00);
    set_guard(1'b1);
    wr_reg(1, 8'h80);
    strobe(1, 6);
    rd_reg(1, d);
    chk("R9 plain bit written while guarded", d, 8'h80);
    set_guard(1'b0);
    rd_reg(1, d);
    chk("R9 plain bit after release", d, 8'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_open_strobe();
    t_priority();
    t_guard_hidden();
    t_neighbour();
    t_same_bit();
    t_release_strobe();
    t_shadow_empty();
    t_nonshared();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule